// File: doc/BRIEF.md
# Interval Timer with Wake-Up Clock Stabilization

This block is an 8-bit interval timer that advances once per divided tick. The tick is taken from the input clock through a prescaler whose ratio comes from a small select field. When the counter runs past its top value it wraps to zero, counting goes on, and an interrupt pending flag is raised. The flag stays up until the interrupt controller acknowledges it. One full interval is 256 ticks.

The same counter also acts as the start-up delay for the oscillator. On power-on reset, or when an external interrupt ends Stop mode, the block enters a stabilizing phase. During that phase the clock enable for the rest of the chip stays low, and it stays low until the low five counter bits carry out, which takes 32 ticks. After reset the slowest prescaler ratio is used. After a wake from Stop, the ratio in force just before Stop was entered is used. While the block is in Stop, the oscillator is treated as off: the prescaler is held and the counter reads zero.

Top module: `bt_wake_timer`

## Requirements
- R1: Outside Stop, the counter rises by exactly one per divided tick and holds between ticks. Select code k (k < 5) gives a tick every 2^(EXP_MAX-2k) input clocks, which with defaults is 2^12, 2^10, 2^8, 2^6 or 2^4. Codes 5 to 7 give 2^EXP_MAX. The select input is captured on every edge while running, and the captured code drives the prescaler from the next cycle.
- R2: A tick at count 255 wraps the counter to 0x00 and counting continues from zero.
- R3: The pending flag rises on the same edge at which the counter wraps from 255 to 0, and it rises at no other time.
- R4: The pending flag stays set until `irq_ack` is high at a clock edge, which clears it. An acknowledge on the same edge as a wrap leaves the flag set.
- R5: Power-on reset gives count 0, no pending flag and `sys_clk_en` low, and starts a stabilization at the slowest ratio (code 0) whatever `div_sel` reads.
- R6: `stop_req` while running clears the counter and drops `sys_clk_en` at the next edge. In Stop the counter stays at zero and further `stop_req` pulses change nothing.
- R7: During stabilization `sys_clk_en` stays low. It rises on the edge at which the counter moves from 31 to 32 (a carry out of bit 4), and the counter keeps counting upward from 32.
- R8: `ext_wake` in Stop starts a stabilization at the next edge, with the counter at zero and the prescaler restarted. The ratio used is the one captured in the last running cycle, so `div_sel` changes made during Stop have no effect on it.
- R9: `ext_wake` while running or stabilizing is ignored. The counter and the clock enable continue as if it were low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock (oscillator output) |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| stop_req | input | 1 | Request to enter Stop mode, honoured while running |
| ext_wake | input | 1 | External interrupt that ends Stop mode |
| div_sel | input | 3 | Prescaler ratio select from the control register |
| irq_ack | input | 1 | Acknowledge that clears the pending flag |
| count | output | 8 | Current counter value |
| irq_pend | output | 1 | Interval-elapsed interrupt pending flag |
| sys_clk_en | output | 1 | Enable that gates the normal clock to the system |

## Verification
On every cycle, the bound checker checks the single-step behaviour of the counter, the wrap to zero, how the pending flag is set and held, the clear on entering Stop, the frozen counter while in Stop, the wake transition, and that the clock enable rises only at count 32. Some properties span many cycles: the exact prescaler ratio chosen by each code, the slow default after reset even when the select input is set to something else, the keeping of the pre-Stop ratio across a wake, and the number of cycles until the clock enable returns. Only the bench's scenarios show these, through its cycle-exact model and its timed waits.

// File: rtl/bt_pkg.sv
package bt_pkg;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_STOP = 2'd1,
    ST_STAB = 2'd2
  } bt_state_e;

  // Map a select code to a prescaler exponent: each step down the code list
  // speeds the tick by 2^exp_step; codes past num_sel fall back to the slowest.
  function automatic int unsigned sel_to_exp(int unsigned sel,
                                             int unsigned exp_max,
                                             int unsigned exp_step,
                                             int unsigned num_sel);
    int unsigned dec;
    if (sel >= num_sel) return exp_max;
    dec = exp_step * sel;
    if (dec > exp_max) return 0;
    return exp_max - dec;
  endfunction

endpackage

// File: rtl/bt_prescaler.sv
module bt_prescaler #(
  parameter int unsigned SEL_W    = 3,
  parameter int unsigned EXP_MAX  = 12,
  parameter int unsigned EXP_STEP = 2,
  parameter int unsigned NUM_SEL  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_on,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  import bt_pkg::*;

  localparam int unsigned PRE_W = (EXP_MAX < 1) ? 1 : EXP_MAX;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] limit;
  int unsigned      cur_exp;

  always_comb begin
    cur_exp = sel_to_exp(32'(sel), EXP_MAX, EXP_STEP, NUM_SEL);
    limit   = PRE_W'((32'd1 << cur_exp) - 32'd1);
  end

  // A late change to a faster ratio can leave pre_q above the new limit;
  // the >= compare ends that period at once instead of wrapping around.
  assign tick = osc_on && (pre_q >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pre_q <= '0;
    else if (!osc_on) pre_q <= '0;
    else if (tick)    pre_q <= '0;
    else              pre_q <= pre_q + PRE_W'(1);
  end

endmodule

// File: rtl/bt_counter.sv
module bt_counter #(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned STAB_BIT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr,
  input  logic             irq_ack,
  output logic [CNT_W-1:0] count,
  output logic             irq_pend,
  output logic             ovf,
  output logic             low_carry
);

  logic [CNT_W-1:0] cnt_q;
  logic             pend_q;

  assign ovf       = tick && (&cnt_q);
  assign low_carry = tick && (&cnt_q[STAB_BIT:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (clr)  cnt_q <= '0;
    else if (tick) cnt_q <= cnt_q + CNT_W'(1);
  end

  // Set wins over acknowledge so that a coincident wrap is never lost.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= ovf || (pend_q && !irq_ack);
  end

  assign count    = cnt_q;
  assign irq_pend = pend_q;

endmodule

// File: rtl/bt_wake_seq.sv
module bt_wake_seq #(
  parameter int unsigned SEL_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               stop_req,
  input  logic               ext_wake,
  input  logic [SEL_W-1:0]   div_sel,
  input  logic               low_carry,
  output bt_pkg::bt_state_e  state,
  output logic [SEL_W-1:0]   sel_q,
  output logic               enter_stop,
  output logic               stab_done,
  output logic               sys_clk_en
);
  import bt_pkg::*;

  bt_state_e st_q, st_d;

  assign enter_stop = (st_q == ST_RUN) && stop_req;
  assign stab_done  = (st_q == ST_STAB) && low_carry;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_RUN:  if (stop_req)  st_d = ST_STOP;
      ST_STOP: if (ext_wake)  st_d = ST_STAB;
      ST_STAB: if (stab_done) st_d = ST_RUN;
      default: st_d = ST_STAB;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_STAB;
    else        st_q <= st_d;
  end

  // Ratio is captured only while running; Stop and stabilization keep it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              sel_q <= '0;
    else if (st_q == ST_RUN) sel_q <= div_sel;
  end

  assign state      = st_q;
  assign sys_clk_en = (st_q == ST_RUN);

endmodule

// File: rtl/bt_wake_timer.sv
module bt_wake_timer #(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned SEL_W    = 3,
  parameter int unsigned EXP_MAX  = 12,
  parameter int unsigned EXP_STEP = 2,
  parameter int unsigned NUM_SEL  = 5,
  parameter int unsigned STAB_BIT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_req,
  input  logic             ext_wake,
  input  logic [SEL_W-1:0] div_sel,
  input  logic             irq_ack,
  output logic [CNT_W-1:0] count,
  output logic             irq_pend,
  output logic             sys_clk_en
);
  import bt_pkg::*;

  // Named internal events, visible to the bound checker.
  bt_state_e        state;
  logic [SEL_W-1:0] sel_q;
  logic             tick;
  logic             ovf;
  logic             low_carry;
  logic             stab_done;
  logic             enter_stop;
  logic             osc_on;
  logic             cnt_clr;

  assign osc_on  = (state != ST_STOP);
  assign cnt_clr = enter_stop || (state == ST_STOP);

  bt_wake_seq #(
    .SEL_W(SEL_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .stop_req  (stop_req),
    .ext_wake  (ext_wake),
    .div_sel   (div_sel),
    .low_carry (low_carry),
    .state     (state),
    .sel_q     (sel_q),
    .enter_stop(enter_stop),
    .stab_done (stab_done),
    .sys_clk_en(sys_clk_en)
  );

  bt_prescaler #(
    .SEL_W   (SEL_W),
    .EXP_MAX (EXP_MAX),
    .EXP_STEP(EXP_STEP),
    .NUM_SEL (NUM_SEL)
  ) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .osc_on(osc_on),
    .sel   (sel_q),
    .tick  (tick)
  );

  bt_counter #(
    .CNT_W   (CNT_W),
    .STAB_BIT(STAB_BIT)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .clr      (cnt_clr),
    .irq_ack  (irq_ack),
    .count    (count),
    .irq_pend (irq_pend),
    .ovf      (ovf),
    .low_carry(low_carry)
  );

endmodule

// File: rtl/bt_wake_timer_chk.sv
module bt_wake_timer_chk #(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned STAB_BIT = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stop_req,
  input logic              ext_wake,
  input logic              irq_ack,
  input logic [CNT_W-1:0]  count,
  input logic              irq_pend,
  input logic              sys_clk_en,
  input logic              tick,
  input logic              ovf,
  input logic              enter_stop,
  input bt_pkg::bt_state_e state
);
  import bt_pkg::*;

  localparam logic [CNT_W-1:0] STAB_END = CNT_W'(1 << (STAB_BIT + 1));

  p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !enter_stop && state != ST_STOP) |=> count == $past(count) + 1'b1);

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !enter_stop && state != ST_STOP) |=> $stable(count));

  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> count == '0);

  p_pend_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> irq_pend);

  p_pend_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovf && (!irq_pend || irq_ack)) |=> !irq_pend);

  p_pend_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend && !irq_ack) |=> irq_pend);

  p_stop_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    enter_stop |=> (state == ST_STOP && count == '0 && !sys_clk_en));

  p_stop_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STOP && !ext_wake) |=> (state == ST_STOP && count == '0));

  p_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_clk_en) |-> count == STAB_END);

  p_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STOP && ext_wake) |=> (state == ST_STAB && count == '0));

  p_nowake_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && ext_wake && !stop_req) |=> state == ST_RUN);

endmodule

bind bt_wake_timer bt_wake_timer_chk #(
  .CNT_W   (CNT_W),
  .STAB_BIT(STAB_BIT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .stop_req  (stop_req),
  .ext_wake  (ext_wake),
  .irq_ack   (irq_ack),
  .count     (count),
  .irq_pend  (irq_pend),
  .sys_clk_en(sys_clk_en),
  .tick      (tick),
  .ovf       (ovf),
  .enter_stop(enter_stop),
  .state     (state)
);

// File: tb/bt_wake_timer_tb.sv
module bt_wake_timer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stop_req = 1'b0;
  logic       ext_wake = 1'b0;
  logic [2:0] div_sel = 3'd0;
  logic       irq_ack = 1'b0;
  logic [7:0] count;
  logic       irq_pend;
  logic       sys_clk_en;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit armed  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Bench built with a 16x faster prescaler so that the slow default fits
  // the run: ratios per code 0..4 are 256, 64, 16, 4, 1; codes 5..7 give 256.
  bt_wake_timer #(.EXP_MAX(8)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .stop_req  (stop_req),
    .ext_wake  (ext_wake),
    .div_sel   (div_sel),
    .irq_ack   (irq_ack),
    .count     (count),
    .irq_pend  (irq_pend),
    .sys_clk_en(sys_clk_en)
  );

  function automatic int ratio_of(int code);
    case (code)
      0: return 256;
      1: return 64;
      2: return 16;
      3: return 4;
      4: return 1;
      default: return 256;
    endcase
  endfunction

  // Behavioural reference: mode 0 = running, 1 = stopped, 2 = settling.
  int m_mode = 2, m_phase = 0, m_val = 0, m_code = 0;
  bit m_flag = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 2; m_phase = 0; m_val = 0; m_flag = 1'b0; m_code = 0;
    end else begin
      int  per;
      bit  adv, wrap;
      int  nmode;
      per   = ratio_of(m_code);
      adv   = (m_mode != 1) && (m_phase + 1 >= per);
      wrap  = adv && (m_val == 255);
      nmode = m_mode;
      if (m_mode == 0 && stop_req) nmode = 1;
      else if (m_mode == 1 && ext_wake) nmode = 2;
      else if (m_mode == 2 && adv && (m_val % 32) == 31) nmode = 0;
      if (m_mode == 1 || (m_mode == 0 && stop_req)) m_val = 0;
      else if (adv) m_val = (m_val + 1) % 256;
      if (m_mode == 1 || adv) m_phase = 0; else m_phase = m_phase + 1;
      m_flag = wrap || (m_flag && !irq_ack);
      if (m_mode == 0) m_code = int'(div_sel);
      m_mode = nmode;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (armed && rst_n) begin
      check(int'(count) == m_val, "R1 count vs model", int'(count), m_val);
      check(irq_pend == m_flag, "R3 pending vs model", int'(irq_pend), int'(m_flag));
      check(sys_clk_en == (m_mode == 0), "R7 clock enable vs model",
            int'(sys_clk_en), int'(m_mode == 0));
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc, WD_LIMIT);
      finish_run();
    end
  end

  // Edges until sys_clk_en is seen high, sampled at falling edges.
  task automatic edges_to_enable(input int start, output int n);
    n = start;
    while (!sys_clk_en && n < 20000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic wait_count(input int v);
    for (int i = 0; i < 600; i++) begin
      if (int'(count) == v) break;
      @(negedge clk);
    end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check(count == 8'd0, "R5 reset count", int'(count), 0);
    check(!irq_pend, "R5 reset pending", int'(irq_pend), 0);
    check(!sys_clk_en, "R5 reset clock enable", int'(sys_clk_en), 0);
    div_sel = 3'd4;
    rst_n = 1'b1;
    armed = 1'b1;
    edges_to_enable(0, n);
    check(n == 8192, "R5 default ratio stabilization edges", n, 8192);
    check(count == 8'd32, "R7 count at enable", int'(count), 32);

    // Fast ratio, run into a wrap.
    wait_count(255);
    @(negedge clk);
    check(count == 8'd0, "R2 wrap to zero", int'(count), 0);
    check(irq_pend, "R3 pending after wrap", int'(irq_pend), 1);
    repeat (5) @(negedge clk);
    check(irq_pend, "R4 pending holds without ack", int'(irq_pend), 1);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    check(!irq_pend, "R4 ack clears pending", int'(irq_pend), 0);

    // Ack on the same edge as a wrap.
    wait_count(255);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    check(irq_pend, "R4 coincident ack keeps pending", int'(irq_pend), 1);

    // ext_wake while running is ignored.
    ext_wake = 1'b1;
    @(negedge clk);
    ext_wake = 1'b0;
    check(sys_clk_en, "R9 wake in run ignored", int'(sys_clk_en), 1);

    // Other ratios, including an unused code.
    div_sel = 3'd1;
    repeat (300) @(negedge clk);
    div_sel = 3'd6;
    repeat (600) @(negedge clk);
    div_sel = 3'd2;
    repeat (100) @(negedge clk);

    // Enter Stop with ratio 4 captured.
    div_sel = 3'd3;
    repeat (10) @(negedge clk);
    stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
    check(count == 8'd0, "R6 stop clears count", int'(count), 0);
    check(!sys_clk_en, "R6 stop drops clock enable", int'(sys_clk_en), 0);
    div_sel = 3'd0;
    repeat (20) @(negedge clk);
    stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
    repeat (20) @(negedge clk);
    check(count == 8'd0, "R6 count frozen in stop", int'(count), 0);
    check(!sys_clk_en, "R6 stop_req in stop ignored", int'(sys_clk_en), 0);

    // Wake: pre-Stop ratio 4 gives 1 + 32*4 edges.
    ext_wake = 1'b1;
    @(negedge clk);
    ext_wake = 1'b0;
    check(count == 8'd0, "R8 wake starts from zero", int'(count), 0);
    repeat (40) @(negedge clk);
    ext_wake = 1'b1;
    @(negedge clk);
    ext_wake = 1'b0;
    edges_to_enable(42, n);
    check(n == 129, "R8 R9 wake stabilization edges", n, 129);
    check(count == 8'd32, "R7 count at enable after wake", int'(count), 32);
    repeat (50) @(negedge clk);

    // Reset mid-run with a fast code on div_sel: default ratio still used.
    div_sel = 3'd4;
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(count == 8'd0 && !irq_pend && !sys_clk_en, "R5 reset mid-run",
          int'(count), 0);
    rst_n = 1'b1;
    edges_to_enable(0, n);
    check(n == 8192, "R5 default ratio after second reset", n, 8192);
    repeat (20) @(negedge clk);
    finish_run();
  end

endmodule